// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block caches recent virtual-page to physical-page mappings in front of memory accesses. A requester presents a virtual address and an access kind (read, write or execute). When the mapping is cached, the block returns the physical address one cycle after acceptance, together with a fault code. Each cached mapping carries read, write and execute permissions and a dirty flag. When the mapping is not cached, the block raises a walk request toward an external page-table walker. It installs the entry the walker returns and then retries the held access internally. Only one miss can be outstanding, and new lookups are stalled until that miss has produced its response.

The storage holds 16 sets of 4 ways. The set is chosen by the low four bits of the virtual page number. Within a set, the block fills an invalid way first. When the set is full, it replaces the way picked by a three-bit tree pseudo-LRU. Writing the page-table base register empties the whole structure. A single-page invalidation input drops one mapping after a page-table edit.

The lookup request, the response, the walk request and the refill all use valid/ready. A party that raises valid keeps it and its payload unchanged until ready is seen at a clock edge. The block holds `rsp_valid` and its payload while `rsp_ready` is low, and during that time `req_ready` stays low. `fill_ready` is high only while the block waits for a refill and its response slot is free. The flush and invalidate inputs are single-cycle control pulses that need no handshake.

Top module: `xlate_buf`

## Requirements
- R1: After reset every way is invalid, `req_ready` is 1, and `rsp_valid`, `walk_valid` and `dirty_evt` are 0.
- R2: An access that hits returns `rsp_valid` on the cycle after acceptance. It returns `rsp_paddr` = {stored physical page, low 12 address bits} and `rsp_fault` = 0 (none).
- R3: An access that misses raises `walk_valid` with `walk_vpn` = the access's virtual page (address bits 31:12). Both stay unchanged until `walk_ready`. `req_ready` stays 0 until the miss has produced its response.
- R4: A refill with `fill_v` = 1 is installed, and the held access is retried, giving the translation. A later access to the same page hits without a walk.
- R5: A refill with `fill_v` = 0 ends the access with `rsp_fault` = 1 (page fault) and `rsp_paddr` = 0. It installs nothing, so a repeat access walks again.
- R6: Access code 0 (read) needs R, code 1 (write) needs W and code 2 (execute) needs X. A hit without the needed permission gives `rsp_fault` = 2 (protection) and `rsp_paddr` = 0.
- R7: A permitted write that hits an entry with D clear sets D. In the same cycle as its response, it pulses `dirty_evt` for exactly one cycle, with `dirty_vpn` set to the page. A later write to that page raises no pulse.
- R8: A one-cycle pulse on `table_base_wr` invalidates every entry, so the next access to any previously cached page walks.
- R9: A pulse on `inv_valid` invalidates only the entry whose page equals `inv_vpn`. Other pages in the same set still hit.
- R10: A refill takes the lowest-numbered invalid way of its set. In a full set it takes the pseudo-LRU victim of a 3-bit tree (root, left, right). Each hit or refill of way w points the tree away from w. Example: after ways 0 to 3 fill in order and way 0 then hits, the next refill replaces way 2.
- R11: While `rsp_ready` is 0, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold steady and `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| table_base_wr | input | 1 | Page-table base written: invalidate all entries |
| inv_valid | input | 1 | Invalidate one page this cycle |
| inv_vpn | input | 20 | Page to invalidate |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 page fault, 2 protection fault |
| walk_valid | output | 1 | Walk request valid |
| walk_ready | input | 1 | Walk request accepted |
| walk_vpn | output | 20 | Page to walk |
| fill_valid | input | 1 | Refill entry valid |
| fill_ready | output | 1 | Refill accepted |
| fill_v | input | 1 | Refilled entry is a valid mapping |
| fill_r | input | 1 | Read permission |
| fill_w | input | 1 | Write permission |
| fill_x | input | 1 | Execute permission |
| fill_d | input | 1 | Dirty flag |
| fill_ppn | input | 20 | Physical page number |
| dirty_evt | output | 1 | One-cycle pulse: dirty flag newly set |
| dirty_vpn | output | 20 | Page whose dirty flag was set |

## Verification
The hold properties on the response and walk channels assume that the external side obeys valid/ready. They also assume that a refill arrives only after its walk request was accepted. The bench's walker answers one walk with one refill, taken from its own page table, and keeps `fill_valid` raised until `fill_ready`. The single-match property assumes that no page is installed twice. This holds because a refill only follows a miss on that same page, and lookups are stalled during the miss. The bench therefore never issues an invalidation or flush while a walk is pending.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef enum logic [1:0] {ACC_RD = 2'd0, ACC_WR = 2'd1, ACC_EX = 2'd2} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_PAGE = 2'd1, FLT_PROT = 2'd2} flt_e;
  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_FILL, ST_RETRY} st_e;

  // tree bits: [0] root (1 = victim in upper half), [1] lower pair, [2] upper pair
  function automatic logic [WAY_W-1:0] plru_pick(input logic [2:0] t);
    if (t[0]) return t[2] ? 2'd3 : 2'd2;
    return t[1] ? 2'd1 : 2'd0;
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [WAY_W-1:0] w);
    logic [2:0] n;
    n = t;
    case (w)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction
endpackage

// File: rtl/xlate_match.sv
module xlate_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           tag,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign hit_vec[g] = vld[g] && (tags[g] == tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (hit_vec[w]) hit_way = WAY_W'(w);
  end
endmodule

// File: rtl/xlate_perm.sv
module xlate_perm
  import xlate_pkg::*;
(
  input  logic [1:0] acc,
  input  logic       can_r,
  input  logic       can_w,
  input  logic       can_x,
  output logic       ok
);
  always_comb begin
    case (acc)
      ACC_RD:  ok = can_r;
      ACC_WR:  ok = can_w;
      ACC_EX:  ok = can_x;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/xlate_plru.sv
module xlate_plru
  import xlate_pkg::*;
#(
  parameter int IDX_W = 4,
  localparam int SETS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_set,
  input  logic [WAY_W-1:0] upd_way,
  input  logic [IDX_W-1:0] rd_set,
  input  logic [WAYS-1:0]  rd_vld,
  output logic [WAY_W-1:0] victim
);
  logic [2:0] tree_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               tree_q[s] <= '0;
      else if (upd_en && upd_set == IDX_W'(s))  tree_q[s] <= plru_touch(tree_q[s], upd_way);
    end
  end

  always_comb begin
    victim = plru_pick(tree_q[rd_set]);
    if (rd_vld != '1)
      for (int w = WAYS - 1; w >= 0; w--)
        if (!rd_vld[w]) victim = WAY_W'(w);
  end

  AST_FILL_PREFERS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld != '1) |-> !rd_vld[victim]); // R10
endmodule

// File: rtl/xlate_buf.sv
module xlate_buf
  import xlate_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int SETS  = 16,
  localparam int IDX_W = $clog2(SETS),
  localparam int VPN_W = VA_W - OFF_W,
  localparam int TAG_W = VPN_W - IDX_W,
  localparam int PPN_W = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             table_base_wr,
  input  logic             inv_valid,
  input  logic [VPN_W-1:0] inv_vpn,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_acc,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic [1:0]       rsp_fault,
  output logic             walk_valid,
  input  logic             walk_ready,
  output logic [VPN_W-1:0] walk_vpn,
  input  logic             fill_valid,
  output logic             fill_ready,
  input  logic             fill_v,
  input  logic             fill_r,
  input  logic             fill_w,
  input  logic             fill_x,
  input  logic             fill_d,
  input  logic [PPN_W-1:0] fill_ppn,
  output logic             dirty_evt,
  output logic [VPN_W-1:0] dirty_vpn
);
  st_e state_q;
  logic [VA_W-1:0] hold_vaddr;
  logic [1:0]      hold_acc;

  logic [WAYS-1:0]  vld_q [SETS];
  logic [WAYS-1:0]  r_q [SETS], w_q [SETS], x_q [SETS], d_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [PPN_W-1:0] ppn_q [SETS][WAYS];

  // lookup source: new request when idle, the held access otherwise
  logic [VA_W-1:0]  lk_vaddr;
  logic [1:0]       lk_acc;
  logic [VPN_W-1:0] lk_vpn;
  logic [IDX_W-1:0] lk_set;
  logic [TAG_W-1:0] lk_tag;
  assign lk_vaddr = (state_q == ST_IDLE) ? req_vaddr : hold_vaddr;
  assign lk_acc   = (state_q == ST_IDLE) ? req_acc   : hold_acc;
  assign lk_vpn   = lk_vaddr[VA_W-1:OFF_W];
  assign lk_set   = lk_vpn[IDX_W-1:0];
  assign lk_tag   = lk_vpn[VPN_W-1:IDX_W];

  logic [WAYS-1:0][TAG_W-1:0] set_tags;
  always_comb
    for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[lk_set][w];

  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way, victim;
  logic             perm_ok;

  xlate_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .vld(vld_q[lk_set]), .tags(set_tags), .tag(lk_tag),
    .hit_vec(hit_vec), .hit(hit), .hit_way(hit_way));

  xlate_perm u_perm (
    .acc(lk_acc), .can_r(r_q[lk_set][hit_way]), .can_w(w_q[lk_set][hit_way]),
    .can_x(x_q[lk_set][hit_way]), .ok(perm_ok));

  logic out_free, do_lookup, fill_fire, set_dirty;
  assign out_free   = !rsp_valid || rsp_ready;
  assign req_ready  = (state_q == ST_IDLE) && out_free;
  assign do_lookup  = (req_valid && req_ready) || (state_q == ST_RETRY && out_free);
  assign fill_ready = (state_q == ST_FILL) && out_free;
  assign fill_fire  = fill_valid && fill_ready;
  assign walk_valid = (state_q == ST_WALK);
  assign walk_vpn   = hold_vaddr[VA_W-1:OFF_W];
  assign set_dirty  = do_lookup && hit && perm_ok && lk_acc == ACC_WR && !d_q[lk_set][hit_way];

  xlate_plru #(.IDX_W(IDX_W)) u_plru (
    .clk(clk), .rst_n(rst_n),
    .upd_en((do_lookup && hit) || (fill_fire && fill_v)),
    .upd_set(lk_set), .upd_way(fill_fire ? victim : hit_way),
    .rd_set(lk_set), .rd_vld(vld_q[lk_set]), .victim(victim));

  logic [IDX_W-1:0] inv_set;
  logic [TAG_W-1:0] inv_tag;
  assign inv_set = inv_vpn[IDX_W-1:0];
  assign inv_tag = inv_vpn[VPN_W-1:IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      hold_vaddr <= '0;
      hold_acc   <= '0;
      rsp_valid  <= 1'b0;
      rsp_paddr  <= '0;
      rsp_fault  <= FLT_NONE;
      dirty_evt  <= 1'b0;
      dirty_vpn  <= '0;
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else begin
      dirty_evt <= 1'b0;
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      case (state_q)
        ST_WALK: if (walk_ready) state_q <= ST_FILL;
        ST_FILL: if (fill_fire) begin
          if (fill_v) begin
            vld_q[lk_set][victim] <= 1'b1;
            state_q <= ST_RETRY;
          end else begin
            rsp_valid <= 1'b1;
            rsp_paddr <= '0;
            rsp_fault <= FLT_PAGE;
            state_q   <= ST_IDLE;
          end
        end
        default: ;
      endcase
      if (do_lookup) begin
        if (hit) begin
          rsp_valid <= 1'b1;
          rsp_paddr <= perm_ok ? {ppn_q[lk_set][hit_way], lk_vaddr[OFF_W-1:0]} : '0;
          rsp_fault <= perm_ok ? FLT_NONE : FLT_PROT;
          state_q   <= ST_IDLE;
          if (set_dirty) begin
            dirty_evt <= 1'b1;
            dirty_vpn <= lk_vpn;
          end
        end else begin
          hold_vaddr <= lk_vaddr;
          hold_acc   <= lk_acc;
          state_q    <= ST_WALK;
        end
      end
      if (inv_valid)
        for (int w = 0; w < WAYS; w++)
          if (tag_q[inv_set][w] == inv_tag) vld_q[inv_set][w] <= 1'b0;
      if (table_base_wr)
        for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_fire && fill_v) begin
      tag_q[lk_set][victim] <= lk_tag;
      ppn_q[lk_set][victim] <= fill_ppn;
      r_q[lk_set][victim]   <= fill_r;
      w_q[lk_set][victim]   <= fill_w;
      x_q[lk_set][victim]   <= fill_x;
      d_q[lk_set][victim]   <= fill_d;
    end
    if (set_dirty) d_q[lk_set][hit_way] <= 1'b1;
  end

  logic any_vld;
  always_comb begin
    any_vld = 1'b0;
    for (int s = 0; s < SETS; s++) any_vld = any_vld | (|vld_q[s]);
  end

  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    do_lookup |-> $onehot0(hit_vec)); // R4
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> !req_ready); // R3
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_valid && !walk_ready) |=> (walk_valid && $stable(walk_vpn))); // R3
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R11
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    table_base_wr |=> !any_vld); // R8
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0)); // R6
endmodule

// File: tb/test_xlate_buf.sv
`timescale 1ns/1ps
module test_xlate_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        table_base_wr = 0, inv_valid = 0;
  logic [19:0] inv_vpn = '0;
  logic        req_valid = 0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid, rsp_ready = 1;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        walk_valid, walk_ready = 0;
  logic [19:0] walk_vpn;
  logic        fill_valid = 0, fill_ready;
  logic        fill_v = 0, fill_r = 0, fill_w = 0, fill_x = 0, fill_d = 0;
  logic [19:0] fill_ppn = '0;
  logic        dirty_evt;
  logic [19:0] dirty_vpn;

  xlate_buf i_xlate_buf (.*);

  int tests = 0, fails = 0;

  // bench page table, indexed by low 8 bits of the page
  logic [255:0] pt_v = '0, pt_r = '0, pt_w = '0, pt_x = '0, pt_d = '0;
  logic [19:0]  pt_ppn [256];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_pte(input int vpn, input bit v, r, w, x, d, input logic [19:0] ppn);
    pt_v[vpn] = v; pt_r[vpn] = r; pt_w[vpn] = w; pt_x[vpn] = x; pt_d[vpn] = d;
    pt_ppn[vpn] = ppn;
  endtask

  task automatic pulse_flush();
    @(negedge clk); table_base_wr = 1;
    @(negedge clk); table_base_wr = 0;
  endtask

  task automatic pulse_inv(input logic [19:0] vpn);
    @(negedge clk); inv_valid = 1; inv_vpn = vpn;
    @(negedge clk); inv_valid = 0;
  endtask

  // one access, serving any walk from the bench page table
  task automatic access(input logic [31:0] va, input logic [1:0] acc,
                        output logic [31:0] pa, output logic [1:0] flt,
                        output bit walked, output bit dirt, output logic [19:0] dvpn,
                        output logic [19:0] wvpn, output int lat);
    bit done = 0;
    int guard = 0;
    walked = 0; dirt = 0; lat = 0; pa = '0; flt = '0; dvpn = '0; wvpn = '0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_acc = acc;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!done && guard < 200) begin
      guard++;
      if (rsp_valid) begin
        pa = rsp_paddr; flt = rsp_fault; dirt = dirty_evt; dvpn = dirty_vpn; done = 1;
      end else if (walk_valid) begin
        walked = 1; wvpn = walk_vpn;
        chk(req_ready == 0, "R3", "req_ready during miss", 64'(req_ready), 0);
        walk_ready = 1;
        @(negedge clk); walk_ready = 0;
        fill_valid = 1; fill_v = pt_v[wvpn[7:0]]; fill_r = pt_r[wvpn[7:0]];
        fill_w = pt_w[wvpn[7:0]]; fill_x = pt_x[wvpn[7:0]]; fill_d = pt_d[wvpn[7:0]];
        fill_ppn = pt_ppn[wvpn[7:0]];
        while (!fill_ready) @(negedge clk);
        @(negedge clk); fill_valid = 0;
        lat += 2;
      end else begin
        @(negedge clk); lat++;
      end
    end
    chk(done, "R2", "response arrived", 64'(done), 1);
  endtask

  logic [31:0] pa; logic [1:0] flt; bit wk, dt; logic [19:0] dv, wv; int lat;

  task automatic t_reset();
    @(negedge clk);
    chk(req_ready == 1, "R1", "req_ready after reset", 64'(req_ready), 1);
    chk(rsp_valid == 0, "R1", "rsp_valid after reset", 64'(rsp_valid), 0);
    chk(walk_valid == 0, "R1", "walk_valid after reset", 64'(walk_valid), 0);
    chk(dirty_evt == 0, "R1", "dirty_evt after reset", 64'(dirty_evt), 0);
  endtask

  task automatic t_miss_then_hit();
    set_pte(5, 1, 1, 1, 1, 1, 20'hABCDE);
    access(32'h0000_5123, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(wk, "R3", "first access walks", 64'(wk), 1);
    chk(wv == 20'h5, "R3", "walk_vpn", 64'(wv), 5);
    chk(pa == 32'hABCD_E123, "R4", "refilled paddr", 64'(pa), 64'h ABCDE123);
    chk(flt == 0, "R4", "refilled fault", 64'(flt), 0);
    access(32'h0000_5FF0, 2'd2, pa, flt, wk, dt, dv, wv, lat);
    chk(!wk, "R4", "second access no walk", 64'(wk), 0);
    chk(lat == 0, "R2", "hit latency", 64'(lat), 0);
    chk(pa == 32'hABCD_EFF0, "R2", "hit paddr", 64'(pa), 64'hABCDEFF0);
    chk(flt == 0, "R2", "hit fault", 64'(flt), 0);
  endtask

  task automatic t_backpressure();
    logic [31:0] first;
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_vaddr = 32'h0000_5004; req_acc = 2'd0;
    while (!req_ready) @(negedge clk);
    @(negedge clk); req_valid = 0;
    first = rsp_paddr;
    chk(rsp_valid == 1, "R11", "rsp raised", 64'(rsp_valid), 1);
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1, "R11", "rsp held", 64'(rsp_valid), 1);
    chk(rsp_paddr == first && first == 32'hABCD_E004, "R11", "paddr held", 64'(rsp_paddr), 64'hABCDE004);
    chk(req_ready == 0, "R11", "req_ready while stalled", 64'(req_ready), 0);
    rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R11", "rsp drained", 64'(rsp_valid), 0);
    chk(req_ready == 1, "R11", "req_ready restored", 64'(req_ready), 1);
  endtask

  task automatic t_perm();
    set_pte(6, 1, 1, 0, 0, 0, 20'h00066);
    set_pte(7, 1, 0, 0, 1, 0, 20'h00077);
    access(32'h0000_6010, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(flt == 0 && pa == 32'h0006_6010, "R6", "read allowed", 64'(pa), 64'h66010);
    access(32'h0000_6010, 2'd1, pa, flt, wk, dt, dv, wv, lat);
    chk(flt == 2, "R6", "write denied fault", 64'(flt), 2);
    chk(pa == 0, "R6", "write denied paddr", 64'(pa), 0);
    access(32'h0000_6010, 2'd2, pa, flt, wk, dt, dv, wv, lat);
    chk(flt == 2, "R6", "exec denied fault", 64'(flt), 2);
    access(32'h0000_7020, 2'd2, pa, flt, wk, dt, dv, wv, lat);
    chk(flt == 0 && pa == 32'h0007_7020, "R6", "exec allowed", 64'(pa), 64'h77020);
    access(32'h0000_7020, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(flt == 2 && pa == 0, "R6", "read denied", 64'(flt), 2);
  endtask

  task automatic t_page_fault();
    set_pte(8, 0, 1, 1, 1, 0, 20'h00088);
    access(32'h0000_8000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(wk && flt == 1, "R5", "invalid refill faults", 64'(flt), 1);
    chk(pa == 0, "R5", "page fault paddr", 64'(pa), 0);
    access(32'h0000_8000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(wk, "R5", "not installed, walks again", 64'(wk), 1);
  endtask

  task automatic t_dirty();
    set_pte(9, 1, 1, 1, 0, 0, 20'h00099);
    access(32'h0000_9000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(!dt, "R7", "read raises no dirty", 64'(dt), 0);
    access(32'h0000_9000, 2'd1, pa, flt, wk, dt, dv, wv, lat);
    chk(dt, "R7", "write sets dirty", 64'(dt), 1);
    chk(dv == 20'h9, "R7", "dirty_vpn", 64'(dv), 9);
    @(negedge clk);
    chk(dirty_evt == 0, "R7", "pulse one cycle", 64'(dirty_evt), 0);
    access(32'h0000_9000, 2'd1, pa, flt, wk, dt, dv, wv, lat);
    chk(!dt && flt == 0, "R7", "second write no pulse", 64'(dt), 0);
  endtask

  task automatic t_flush();
    pulse_flush();
    access(32'h0000_5000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(wk, "R8", "walk after flush", 64'(wk), 1);
    chk(pa == 32'hABCD_E000, "R8", "paddr after flush", 64'(pa), 64'hABCDE000);
  endtask

  task automatic t_inval();
    set_pte(8'h15, 1, 1, 1, 1, 1, 20'h00150);
    set_pte(8'h25, 1, 1, 1, 1, 1, 20'h00250);
    access(32'h0001_5000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    access(32'h0002_5000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    pulse_inv(20'h15);
    access(32'h0001_5000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(wk, "R9", "invalidated page walks", 64'(wk), 1);
    access(32'h0002_5000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(!wk && pa == 32'h0025_0000, "R9", "neighbour still hits", 64'(wk), 0);
  endtask

  task automatic t_replace();
    for (int i = 0; i < 5; i++) set_pte(i * 16, 1, 1, 1, 1, 1, 20'(32'h300 + i));
    pulse_flush();
    for (int i = 0; i < 4; i++)
      access(32'(i * 16) << 12, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    access(32'h0000_0000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(!wk, "R10", "way0 hit", 64'(wk), 0);
    access(32'h0004_0000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(wk && pa == 32'h0030_4000, "R10", "new page installed", 64'(pa), 64'h304000);
    for (int i = 0; i < 5; i++) begin
      if (i == 2) continue;
      access(32'(i * 16) << 12, 2'd0, pa, flt, wk, dt, dv, wv, lat);
      chk(!wk, "R10", $sformatf("page %0h kept", i * 16), 64'(wk), 0);
    end
    access(32'h0002_0000, 2'd0, pa, flt, wk, dt, dv, wv, lat);
    chk(wk, "R10", "way2 page evicted", 64'(wk), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_miss_then_hit();
    t_backpressure();
    t_perm();
    t_page_fault();
    t_dirty();
    t_flush();
    t_inval();
    t_replace();
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule